// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Machine-Check Routing

This block collects a bank of interrupt source events, holds each one in a pending bit until software clears it, and raises two request classes. The machine-check class is fed only by a fixed set of error sources and ignores the mask. The normal class covers every other source that is pending and enabled. A 6-bit vector output names the normal source that has the highest current priority. A core-enable input chooses whether the two requests drive the internal core lines or the external interrupt pins.

Priority runs from low source index to high. Two programmable features change this order. A group-order field rearranges three contiguous groups of peripheral sources within their band of the chain. A promote register lets one normal source win over every other source. The request outputs are built by a four-state request-class machine. RQ_IDLE means no request. RQ_INT means only the normal request is active, RQ_MCP means only the machine-check request is active, and RQ_BOTH means both are active. The machine moves each clock edge straight to the state that matches the current pair {machine-check pending, normal pending}. Any transition between any two of the four states is allowed, and synchronous reset forces RQ_IDLE.

Top module: `irq_ctrl_top`

## Requirements
- R1: A high source input sets its pending bit at the next clock edge. The bit stays set after the input falls, until a 1 is written to that bit of the clear input. If a set and a clear arrive in the same cycle, the set wins.
- R2: A mask bit of 1 enables its source. The normal request is active exactly when some enabled source outside the machine-check set is pending. A mask change also applies to bits that are already pending.
- R3: The vector output is the winning source index plus 1, or 0 when no normal request is active. It updates one clock edge after the pending and mask state it reflects, which is two edges after the source event.
- R4: With default configuration, a lower source index has higher priority.
- R5: Sources 8..31 form groups 0, 1 and 2, with 8 sources each. The order field holds one 2-bit group number per slot: bits [1:0] for slot 0 (the highest), bits [3:2] for slot 1 and bits [5:4] for slot 2. The slots occupy ranks 8..31. A field that contains a value of 3 or a repeated group is treated as the default value 6'b10_01_00.
- R6: When promote-enable is set, the source whose index equals the promote ID wins if it is a pending, enabled normal source. An ID of 37 or more, or an ID of a machine-check source, has no effect.
- R7: Sources 0..4 form the machine-check set. The machine-check request is active whenever any of them is pending, whatever the mask. These sources never raise the normal request and never appear in the vector.
- R8: When the core-enable input is 1, the requests drive core_mcp_o and core_int_o. When it is 0, they drive ext_nmi_o and ext_int_o instead. The inactive pair of outputs stays 0. The change takes effect one edge after core-enable changes.
- R9: Synchronous reset clears all pending and mask bits, all request outputs and the vector. It also restores the default group order and turns promotion off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 37 | Source event inputs; a high level sets the pending bit |
| pend_clr_i | input | 37 | Write-1-to-clear strobes for the pending bits |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 37 | Mask write data, 1 = enabled |
| cfg_we_i | input | 1 | Priority configuration write enable |
| cfg_order_i | input | 6 | Group order field, 2 bits per slot |
| cfg_promo_en_i | input | 1 | Promotion enable |
| cfg_promo_id_i | input | 6 | Index of the promoted source |
| core_en_i | input | 1 | 1 = internal core takes the requests |
| pend_o | output | 37 | Pending register read value |
| vec_o | output | 6 | Vector register, 0 = none |
| core_int_o | output | 1 | Normal request to the internal core |
| core_mcp_o | output | 1 | Machine-check request to the internal core |
| ext_int_o | output | 1 | Normal request on the external pin |
| ext_nmi_o | output | 1 | Machine-check request on the external pin |

## Verification
A source event, a clear or a configuration write reaches the pending, mask or configuration registers at the first edge. It reaches the vector and request outputs at the second edge, so pend_o is due one edge after a stimulus and the vector and requests are due two edges after it. Core-enable passes through one register, so the routing change is due one edge after the input changes. The bench drives every input on the falling edge and samples on a falling edge counted from the drive point. For each table row it clears all pending bits, writes the configuration, pulses the events for one cycle, and then checks pend_o, the vector and all four request pins on the falling edge after the second rising edge.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_INT  = 2'd1,
        RQ_MCP  = 2'd2,
        RQ_BOTH = 2'd3
    } req_state_t;
endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NSRC = 37
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] evt_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_wdata_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] mask_o
);
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] mask_q;

    // a new event has priority over a clear strobe in the same cycle
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_i) | evt_i;
            if (mask_we_i) begin
                mask_q <= mask_wdata_i;
            end
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
    parameter int              NSRC     = 37,
    parameter int              NGRP     = 3,
    parameter int              GRP_BASE = 8,
    parameter int              GRP_SIZE = 8,
    parameter int              VW       = 6,
    parameter logic [NSRC-1:0] MC_SET   = 37'h1F,
    localparam int             GW       = $clog2(NGRP),
    localparam int             OW       = NGRP * GW
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] pend_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            cfg_we_i,
    input  logic [OW-1:0]   cfg_order_i,
    input  logic            cfg_promo_en_i,
    input  logic [VW-1:0]   cfg_promo_id_i,
    output logic [VW-1:0]   win_vec_o,
    output logic            int_req_o,
    output logic            mcp_req_o
);
    localparam int SW       = $clog2(NSRC);
    localparam int BAND_END = GRP_BASE + NGRP * GRP_SIZE;

    logic [OW-1:0] order_q;
    logic          promo_en_q;
    logic [VW-1:0] promo_id_q;

    // default order: slot i holds group i
    function automatic logic [OW-1:0] default_order();
        logic [OW-1:0] v;
        v = '0;
        for (int i = 0; i < NGRP; i++) begin
            v[i*GW +: GW] = GW'(i);
        end
        return v;
    endfunction

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            order_q    <= default_order();
            promo_en_q <= 1'b0;
            promo_id_q <= '0;
        end else if (cfg_we_i) begin
            order_q    <= cfg_order_i;
            promo_en_q <= cfg_promo_en_i;
            promo_id_q <= cfg_promo_id_i;
        end
    end

    logic [NSRC-1:0] cand;
    assign cand      = pend_i & mask_i & ~MC_SET;
    assign int_req_o = |cand;
    assign mcp_req_o = |(pend_i & MC_SET);

    // validate the order field; an illegal field falls back to the default
    logic          order_ok;
    logic [GW-1:0] gsel [NGRP];

    always_comb begin
        order_ok = 1'b1;
        for (int i = 0; i < NGRP; i++) begin
            if (int'(order_q[i*GW +: GW]) >= NGRP) begin
                order_ok = 1'b0;
            end
            for (int j = 0; j < i; j++) begin
                if (order_q[i*GW +: GW] == order_q[j*GW +: GW]) begin
                    order_ok = 1'b0;
                end
            end
        end
        for (int i = 0; i < NGRP; i++) begin
            gsel[i] = order_ok ? order_q[i*GW +: GW] : GW'(i);
        end
    end

    // rank r of the chain is served by source map_idx[r]
    logic [SW-1:0]   map_idx [NSRC];
    logic [NSRC-1:0] ranked;

    for (genvar r = 0; r < NSRC; r++) begin : g_rank
        if (r >= GRP_BASE && r < BAND_END) begin : g_band
            localparam int SLOT = (r - GRP_BASE) / GRP_SIZE;
            localparam int OFS  = (r - GRP_BASE) % GRP_SIZE;
            always_comb begin
                map_idx[r] = SW'(GRP_BASE + int'(gsel[SLOT]) * GRP_SIZE + OFS);
            end
        end else begin : g_fixed
            always_comb begin
                map_idx[r] = SW'(r);
            end
        end
        assign ranked[r] = cand[map_idx[r]];
    end

    logic          chain_found;
    logic [SW-1:0] chain_idx;

    always_comb begin
        chain_found = 1'b0;
        chain_idx   = '0;
        for (int r = NSRC - 1; r >= 0; r--) begin
            if (ranked[r]) begin
                chain_found = 1'b1;
                chain_idx   = map_idx[r];
            end
        end
    end

    logic          promo_hit;
    logic [SW-1:0] promo_idx;

    assign promo_idx = promo_id_q[SW-1:0];
    assign promo_hit = promo_en_q && (int'(promo_id_q) < NSRC) && cand[promo_idx];

    always_comb begin
        if (promo_hit) begin
            win_vec_o = VW'(promo_idx) + VW'(1);
        end else if (chain_found) begin
            win_vec_o = VW'(chain_idx) + VW'(1);
        end else begin
            win_vec_o = '0;
        end
    end
endmodule

// File: rtl/irq_route.sv
module irq_route
    import irq_pkg::*;
#(
    parameter int VW = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          int_req_i,
    input  logic          mcp_req_i,
    input  logic          core_en_i,
    input  logic [VW-1:0] win_vec_i,
    output logic [VW-1:0] vec_o,
    output logic          core_int_o,
    output logic          core_mcp_o,
    output logic          ext_int_o,
    output logic          ext_nmi_o
);
    req_state_t    state_q;
    req_state_t    state_d;
    logic          core_en_q;
    logic [VW-1:0] vec_q;

    always_comb begin
        unique case ({mcp_req_i, int_req_i})
            2'b00: state_d = RQ_IDLE;
            2'b01: state_d = RQ_INT;
            2'b10: state_d = RQ_MCP;
            2'b11: state_d = RQ_BOTH;
            default: state_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q   <= RQ_IDLE;
            core_en_q <= 1'b1;
            vec_q     <= '0;
        end else begin
            state_q   <= state_d;
            core_en_q <= core_en_i;
            vec_q     <= win_vec_i;
        end
    end

    logic int_act;
    logic mcp_act;

    always_comb begin
        unique case (state_q)
            RQ_IDLE: begin int_act = 1'b0; mcp_act = 1'b0; end
            RQ_INT:  begin int_act = 1'b1; mcp_act = 1'b0; end
            RQ_MCP:  begin int_act = 1'b0; mcp_act = 1'b1; end
            RQ_BOTH: begin int_act = 1'b1; mcp_act = 1'b1; end
            default: begin int_act = 1'b0; mcp_act = 1'b0; end
        endcase
        core_int_o = int_act & core_en_q;
        core_mcp_o = mcp_act & core_en_q;
        ext_int_o  = int_act & ~core_en_q;
        ext_nmi_o  = mcp_act & ~core_en_q;
    end

    assign vec_o = vec_q;
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top #(
    parameter int              NSRC     = 37,
    parameter int              NGRP     = 3,
    parameter int              GRP_BASE = 8,
    parameter int              GRP_SIZE = 8,
    parameter int              VW       = 6,
    parameter logic [NSRC-1:0] MC_SET   = 37'h1F,
    localparam int             GW       = $clog2(NGRP),
    localparam int             OW       = NGRP * GW
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] pend_clr_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_wdata_i,
    input  logic            cfg_we_i,
    input  logic [OW-1:0]   cfg_order_i,
    input  logic            cfg_promo_en_i,
    input  logic [VW-1:0]   cfg_promo_id_i,
    input  logic            core_en_i,
    output logic [NSRC-1:0] pend_o,
    output logic [VW-1:0]   vec_o,
    output logic            core_int_o,
    output logic            core_mcp_o,
    output logic            ext_int_o,
    output logic            ext_nmi_o
);
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] mask_w;
    logic [VW-1:0]   win_vec_w;
    logic            int_req_w;
    logic            mcp_req_w;

    irq_pend_reg #(.NSRC(NSRC)) u_pend (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .evt_i       (src_i),
        .clr_i       (pend_clr_i),
        .mask_we_i   (mask_we_i),
        .mask_wdata_i(mask_wdata_i),
        .pend_o      (pend_w),
        .mask_o      (mask_w)
    );

    irq_prio_sel #(
        .NSRC(NSRC), .NGRP(NGRP), .GRP_BASE(GRP_BASE),
        .GRP_SIZE(GRP_SIZE), .VW(VW), .MC_SET(MC_SET)
    ) u_sel (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .pend_i        (pend_w),
        .mask_i        (mask_w),
        .cfg_we_i      (cfg_we_i),
        .cfg_order_i   (cfg_order_i),
        .cfg_promo_en_i(cfg_promo_en_i),
        .cfg_promo_id_i(cfg_promo_id_i),
        .win_vec_o     (win_vec_w),
        .int_req_o     (int_req_w),
        .mcp_req_o     (mcp_req_w)
    );

    irq_route #(.VW(VW)) u_route (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .int_req_i (int_req_w),
        .mcp_req_i (mcp_req_w),
        .core_en_i (core_en_i),
        .win_vec_i (win_vec_w),
        .vec_o     (vec_o),
        .core_int_o(core_int_o),
        .core_mcp_o(core_mcp_o),
        .ext_int_o (ext_int_o),
        .ext_nmi_o (ext_nmi_o)
    );

    assign pend_o = pend_w;
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int              NSRC   = 37,
    parameter int              VW     = 6,
    parameter logic [NSRC-1:0] MC_SET = 37'h1F
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] mask,
    input logic [NSRC-1:0] clr,
    input logic [VW-1:0]   vec,
    input logic            core_int_o,
    input logic            core_mcp_o,
    input logic            ext_int_o,
    input logic            ext_nmi_o
);
    // R1: a pending bit that was not cleared is never lost
    p_pend_hold_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((($past(pend) & ~$past(clr)) & ~pend) == '0));

    // R2: a normal request implies an enabled normal source was pending
    p_int_src_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (core_int_o || ext_int_o) |-> $past(|(pend & mask & ~MC_SET)));

    // R3: the vector is nonzero exactly while the normal request is active
    p_vec_int_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (vec != '0) == (core_int_o || ext_int_o));

    // R3: the vector never names a source beyond the bank
    p_vec_range_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        int'(vec) <= NSRC);

    // R7: the machine-check request follows the machine-check pending bits
    p_mcp_follow_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        1'b1 |=> ((core_mcp_o || ext_nmi_o) == $past(|(pend & MC_SET))));

    // R8: a request never drives both the core and the external pin
    p_route_excl_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !(core_int_o && ext_int_o) && !(core_mcp_o && ext_nmi_o));
endmodule

bind irq_ctrl_top irq_ctrl_chk #(
    .NSRC(NSRC), .VW(VW), .MC_SET(MC_SET)
) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .pend      (pend_w),
    .mask      (mask_w),
    .clr       (pend_clr_i),
    .vec       (vec_o),
    .core_int_o(core_int_o),
    .core_mcp_o(core_mcp_o),
    .ext_int_o (ext_int_o),
    .ext_nmi_o (ext_nmi_o)
);

// File: tb/irq_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
    localparam int N = 37;
    localparam logic [N-1:0] ALL = {N{1'b1}};
    localparam logic [5:0] DEF = 6'b10_01_00;

    typedef struct packed {
        logic [N-1:0] mask;
        logic [N-1:0] evt;
        logic [5:0]   order;
        logic         pen;
        logic [5:0]   pid;
        logic [5:0]   vec;
        logic         intr;
        logic         mcp;
    } row_t;

    function automatic logic [N-1:0] b(int i);
        return {{(N-1){1'b0}}, 1'b1} << i;
    endfunction

    localparam int NROWS = 14;
    row_t rows [NROWS];

    logic clk = 1'b0;
    logic rst;
    logic [N-1:0] src, clr, mwd;
    logic mwe, cwe, pen, cen;
    logic [5:0] ord, pid;
    logic [N-1:0] pend;
    logic [5:0] vec;
    logic cint, cmcp, eint, enmi;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_ctrl_top dut_i (
        .clk_i(clk), .rst_i(rst), .src_i(src), .pend_clr_i(clr),
        .mask_we_i(mwe), .mask_wdata_i(mwd), .cfg_we_i(cwe),
        .cfg_order_i(ord), .cfg_promo_en_i(pen), .cfg_promo_id_i(pid),
        .core_en_i(cen), .pend_o(pend), .vec_o(vec),
        .core_int_o(cint), .core_mcp_o(cmcp), .ext_int_o(eint), .ext_nmi_o(enmi)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // write mask and config, clear all pending bits, then pulse events
    task automatic run_case(logic [N-1:0] m, logic [5:0] o, logic pe,
                            logic [5:0] pi, logic [N-1:0] e);
        mwe = 1; mwd = m; cwe = 1; ord = o; pen = pe; pid = pi; clr = ALL;
        @(negedge clk);
        mwe = 0; cwe = 0; clr = '0; src = e;
        @(negedge clk);
        src = '0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // R4 default order; R5 group order; R6 promotion; R7 machine check; R2 mask
        rows[0]  = '{ALL, b(10)|b(20), DEF, 1'b0, 6'd0,  6'd11, 1'b1, 1'b0}; // R4
        rows[1]  = '{ALL, b(20)|b(30), 6'b00_01_10, 1'b0, 6'd0, 6'd31, 1'b1, 1'b0}; // R5
        rows[2]  = '{ALL, b(9)|b(17), 6'b10_00_01, 1'b0, 6'd0, 6'd18, 1'b1, 1'b0}; // R5
        rows[3]  = '{ALL, b(6)|b(36), DEF, 1'b1, 6'd36, 6'd37, 1'b1, 1'b0}; // R6
        rows[4]  = '{ALL, b(3), DEF, 1'b0, 6'd0, 6'd0, 1'b0, 1'b1}; // R7
        rows[5]  = '{ALL, b(3)|b(33), DEF, 1'b0, 6'd0, 6'd34, 1'b1, 1'b1}; // R7
        rows[6]  = '{'0, b(12)|b(2), DEF, 1'b0, 6'd0, 6'd0, 1'b0, 1'b1}; // R2 R7
        rows[7]  = '{ALL, b(15)|b(16), 6'b00_00_00, 1'b0, 6'd0, 6'd16, 1'b1, 1'b0}; // R5
        rows[8]  = '{ALL, b(7)|b(35), DEF, 1'b1, 6'd40, 6'd8, 1'b1, 1'b0}; // R6
        rows[9]  = '{b(25), b(8)|b(25), DEF, 1'b0, 6'd0, 6'd26, 1'b1, 1'b0}; // R2
        rows[10] = '{ALL, b(3)|b(20), DEF, 1'b1, 6'd3, 6'd21, 1'b1, 1'b1}; // R6 R7
        rows[11] = '{ALL, b(5)|b(24), 6'b00_01_10, 1'b0, 6'd0, 6'd6, 1'b1, 1'b0}; // R4
        rows[12] = '{ALL, b(0)|b(36), DEF, 1'b1, 6'd36, 6'd37, 1'b1, 1'b1}; // R6
        rows[13] = '{ALL, b(20)|b(28), 6'b11_01_00, 1'b0, 6'd0, 6'd21, 1'b1, 1'b0}; // R5

        rst = 1; src = '0; clr = '0; mwe = 0; mwd = '0; cwe = 0;
        ord = '0; pen = 0; pid = '0; cen = 1;
        repeat (4) @(negedge clk);
        // R9 reset state
        chk("R9 vec", 64'(vec), 0);
        chk("R9 req", 64'({cint, cmcp, eint, enmi}), 0);
        chk("R9 pend", 64'(pend), 0);
        rst = 0;
        // R9 mask cleared by reset: pending set but no request
        src = b(20);
        @(negedge clk); src = '0;
        @(negedge clk);
        chk("R9 mask clear pend", 64'(pend), 64'(b(20)));
        chk("R9 mask clear int", 64'(cint), 0);

        for (int i = 0; i < NROWS; i++) begin
            run_case(rows[i].mask, rows[i].order, rows[i].pen, rows[i].pid, rows[i].evt);
            chk($sformatf("R1 row%0d pend", i), 64'(pend), 64'(rows[i].evt));
            chk($sformatf("R3 row%0d vec", i), 64'(vec), 64'(rows[i].vec));
            chk($sformatf("R2 row%0d int", i), 64'(cint), 64'(rows[i].intr));
            chk($sformatf("R7 row%0d mcp", i), 64'(cmcp), 64'(rows[i].mcp));
            chk($sformatf("R8 row%0d ext", i), 64'({eint, enmi}), 0);
        end

        // R1 hold and write-1-to-clear
        run_case(ALL, DEF, 1'b0, 6'd0, b(10)|b(20));
        chk("R1 held after pulse", 64'(vec), 11);
        clr = b(10);
        @(negedge clk); clr = '0;
        @(negedge clk);
        chk("R1 clear moves vec", 64'(vec), 21);
        chk("R1 clear pend", 64'(pend), 64'(b(20)));
        // R1 set beats clear
        src = b(20); clr = b(20);
        @(negedge clk); src = '0; clr = '0;
        chk("R1 set wins", 64'(pend), 64'(b(20)));

        // R8 external routing
        run_case(ALL, DEF, 1'b0, 6'd0, b(3)|b(33));
        cen = 0;
        @(negedge clk);
        chk("R8 ext pins", 64'({eint, enmi}), 64'(2'b11));
        chk("R8 core pins", 64'({cint, cmcp}), 0);
        cen = 1;
        @(negedge clk);
        chk("R8 back to core", 64'({cint, cmcp, eint, enmi}), 64'(4'b1100));

        // R2 unmasking an already pending source
        run_case('0, DEF, 1'b0, 6'd0, b(12));
        chk("R2 masked", 64'(cint), 0);
        mwe = 1; mwd = b(12);
        @(negedge clk); mwe = 0;
        @(negedge clk);
        chk("R2 unmask int", 64'(cint), 1);
        chk("R3 unmask vec", 64'(vec), 13);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule